// File: doc/BRIEF.md
# Next-PC Sequencer

This block owns the program counter of a simple 32-bit processor and decides, every clock, where the next instruction comes from. The decode stage gives it the 6-bit major opcode and the 6-bit function code of the instruction at the current PC. The block also takes the sign-carrying 16-bit branch displacement, the 26-bit jump field, the equality result of the compare unit and a register operand for indirect jumps. It then loads the PC with one of four values: the following word, a PC-relative branch target, a region-relative absolute target, or the register value.

Calls are supported directly. The address of the following word is presented on a link output at all times. A strobe asks the register file to store it in register 31 during the cycle a call instruction sits at the PC. A return is an indirect jump through that register. Instruction fetch, decode tables and the register file itself are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge the PC becomes 0x00000000, whatever the other inputs are.
- R2: Any opcode other than 2, 3, 4 and 5, and other than opcode 0 with function code 8, advances the PC by 4 at the next edge (for example opcode 0 with function 0x20, or opcode 35).
- R3: Opcode 4 (branch if equal) with `eq_flag` = 1 loads PC+4 + (sign-extended displacement × 4); with `eq_flag` = 0 it loads PC+4.
- R4: Opcode 5 (branch if not equal) with `eq_flag` = 0 loads PC+4 + (sign-extended displacement × 4); with `eq_flag` = 1 it loads PC+4.
- R5: The 16-bit displacement is a two's-complement word count, so 0xFFFE moves back 8 bytes from PC+4 and 0x8000 moves back 131072 bytes.
- R6: Opcode 2 (jump) loads {PC+4 bits 31..28, the 26-bit field, 2'b00}, so a field of 2500 from region 0 lands on address 10000.
- R7: Opcode 3 (call) raises `link_we` for the cycle it is presented, with `link_value` = PC+4, and loads the PC exactly as R6 does.
- R8: Opcode 0 with function code 8 (indirect jump) loads the PC with `jr_value` and leaves `link_we` low.
- R9: `link_value` always equals the current PC + 4, and `link_we` is low for every instruction other than opcode 3.
- R10: The region bits of a jump come from PC+4, not PC, so a jump at 0x0FFFFFFC with field 5 lands on 0x10000014.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Major opcode of the instruction at the PC |
| funct | input | 6 | Function code, used only with opcode 0 |
| br_disp | input | 16 | Two's-complement branch displacement in words |
| jmp_field | input | 26 | Absolute word target inside the current 256 MB region |
| eq_flag | input | 1 | High when the two compared registers are equal |
| jr_value | input | 32 | Register operand used by the indirect jump |
| pc | output | 32 | Current program counter |
| link_value | output | 32 | Address of the following instruction (PC+4) |
| link_we | output | 1 | Write request for register 31 with `link_value` |

## Verification
Some behaviours are checked by assertions on every clock cycle:
- the PC step taken for sequential instructions;
- the sign-extended branch arithmetic whenever a branch condition holds;
- the region-relative jump and call targets;
- the indirect load;
- the pairing of the link strobe with call opcodes only.

Other behaviours show only in the bench's scenarios:
- that untaken branches fall through;
- that the jump region is taken from PC+4 at a region boundary;
- that large negative displacements wrap correctly;
- that reset wins over a jump presented in the same cycle.

// File: rtl/pcseq_pkg.sv
// Package: shared types and opcode constants of the next-PC sequencer.
// Assumes 6-bit major opcodes and 6-bit function codes.
package pcseq_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_JUMP    = 6'd2;
    localparam logic [5:0] OPC_CALL    = 6'd3;
    localparam logic [5:0] OPC_BR_EQ   = 6'd4;
    localparam logic [5:0] OPC_BR_NE   = 6'd5;
    localparam logic [5:0] FN_JUMP_REG = 6'd8;

    // Kind of control transfer requested by the current instruction.
    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_CALL = 3'd4,
        FLOW_JREG = 3'd5
    } flow_t;

endpackage

// File: rtl/pcseq_decode.sv
// Module: pcseq_decode
// Maps opcode and function code onto a flow class. Anything that is not a
// branch, jump, call or indirect jump is treated as sequential.
module pcseq_decode
    import pcseq_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] opcode,
    input  logic [OP_W-1:0] funct,
    output flow_t           flow
);

    // Purpose: classify the instruction at the PC.
    always_comb begin
        unique case (opcode)
            OPC_JUMP:    flow = FLOW_JMP;
            OPC_CALL:    flow = FLOW_CALL;
            OPC_BR_EQ:   flow = FLOW_BEQ;
            OPC_BR_NE:   flow = FLOW_BNE;
            OPC_SPECIAL: flow = (funct == FN_JUMP_REG) ? FLOW_JREG : FLOW_SEQ;
            default:     flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcseq_target.sv
// Module: pcseq_target
// Computes the candidate targets and selects the next PC for a given flow
// class. Assumes word-aligned instructions, so targets carry two zero LSBs.
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 16,
    parameter int FIELD_W = 26
) (
    input  flow_t              flow,
    input  logic [ADDR_W-1:0]  pc_plus4,
    input  logic [OFF_W-1:0]   br_disp,
    input  logic [FIELD_W-1:0] jmp_field,
    input  logic               eq_flag,
    input  logic [ADDR_W-1:0]  jr_value,
    output logic [ADDR_W-1:0]  next_pc
);

    localparam int REGION_W = ADDR_W - FIELD_W - 2;
    localparam int EXT_W    = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] branch_tgt;
    logic [ADDR_W-1:0] jump_tgt;
    logic              take_branch;

    // Purpose: PC-relative target from the sign-extended word displacement.
    always_comb begin
        branch_tgt = pc_plus4 + {{EXT_W{br_disp[OFF_W-1]}}, br_disp, 2'b00};
    end

    // Purpose: region-relative absolute target using the region of PC+4.
    always_comb begin
        jump_tgt = {pc_plus4[ADDR_W-1 -: REGION_W], jmp_field, 2'b00};
    end

    // Purpose: evaluate the branch condition for both branch kinds.
    always_comb begin
        take_branch = ((flow == FLOW_BEQ) && eq_flag) ||
                      ((flow == FLOW_BNE) && !eq_flag);
    end

    // Purpose: pick the next PC.
    always_comb begin
        unique case (flow)
            FLOW_JMP, FLOW_CALL: next_pc = jump_tgt;
            FLOW_JREG:           next_pc = jr_value;
            FLOW_BEQ, FLOW_BNE:  next_pc = take_branch ? branch_tgt : pc_plus4;
            default:             next_pc = pc_plus4;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Holds the program counter and advances it every clock according to the
// instruction at the PC. Raises the link strobe for calls. Assumes the
// decode stage presents opcode, funct and operands for the current PC in the
// same cycle. The reset is synchronous and active low.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 16,
    parameter int FIELD_W = 26,
    parameter int OP_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic [OP_W-1:0]    funct,
    input  logic [OFF_W-1:0]   br_disp,
    input  logic [FIELD_W-1:0] jmp_field,
    input  logic               eq_flag,
    input  logic [ADDR_W-1:0]  jr_value,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  link_value,
    output logic               link_we
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);
    localparam int                REGION_W = ADDR_W - FIELD_W - 2;
    localparam int                EXT_W    = ADDR_W - OFF_W - 2;

    flow_t             flow;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_plus4;
    logic [ADDR_W-1:0] next_pc;

    pcseq_decode #(.OP_W(OP_W)) decode_i (
        .opcode (opcode),
        .funct  (funct),
        .flow   (flow)
    );

    // Purpose: address of the following instruction.
    always_comb begin
        pc_plus4 = pc_q + STEP;
    end

    pcseq_target #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .FIELD_W (FIELD_W)
    ) target_i (
        .flow      (flow),
        .pc_plus4  (pc_plus4),
        .br_disp   (br_disp),
        .jmp_field (jmp_field),
        .eq_flag   (eq_flag),
        .jr_value  (jr_value),
        .next_pc   (next_pc)
    );

    // Purpose: PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= next_pc;
    end

    // Purpose: drive outputs.
    always_comb begin
        pc         = pc_q;
        link_value = pc_plus4;
        link_we    = (flow == FLOW_CALL);
    end

    // R1: reset drives the PC to zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R2: sequential instructions step by one word.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OPC_JUMP && opcode != OPC_CALL && opcode != OPC_BR_EQ &&
         opcode != OPC_BR_NE &&
         !(opcode == OPC_SPECIAL && funct == FN_JUMP_REG))
        |=> pc == $past(pc) + STEP);

    // R3: a taken equal-branch lands at PC+4 plus the scaled displacement.
    a_r3_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BR_EQ && eq_flag)
        |=> pc == $past(link_value) +
                  {{EXT_W{$past(br_disp[OFF_W-1])}}, $past(br_disp), 2'b00});

    // R4: a taken not-equal-branch lands at PC+4 plus the scaled displacement.
    a_r4_bne_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BR_NE && !eq_flag)
        |=> pc == $past(link_value) +
                  {{EXT_W{$past(br_disp[OFF_W-1])}}, $past(br_disp), 2'b00});

    // R6: a jump keeps the region of PC+4 and ends word-aligned.
    a_r6_jump_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_JUMP)
        |=> pc == {$past(link_value[ADDR_W-1 -: REGION_W]), $past(jmp_field), 2'b00});

    // R7: a call jumps like R6.
    a_r7_call_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        link_we
        |=> pc == {$past(link_value[ADDR_W-1 -: REGION_W]), $past(jmp_field), 2'b00});

    // R9: the link strobe appears only for the call opcode.
    a_r9_link_only_call: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> opcode == OPC_CALL);

    // R8: an indirect jump loads the register operand.
    a_r8_jreg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_SPECIAL && funct == FN_JUMP_REG)
        |=> pc == $past(jr_value));

endmodule

// File: tb/pc_sequencer_tb_top.sv
// Bench for pc_sequencer. It walks a vector table from reset and then runs
// directed reset tests.
module pc_sequencer_tb_top;

    typedef struct packed {
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [15:0] disp;
        logic [25:0] fld;
        logic        eq;
        logic [31:0] jrv;
        logic [31:0] exp_pc;
        logic        exp_we;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{6'd0,  6'h20, 16'h0000, 26'd0,    1'b0, 32'h0,        32'h00000004, 1'b0, 8'd2},  // R2 add
        '{6'd35, 6'h00, 16'h0000, 26'd0,    1'b0, 32'h0,        32'h00000008, 1'b0, 8'd2},  // R2 load
        '{6'd4,  6'h00, 16'd25,   26'd0,    1'b1, 32'h0,        32'h00000070, 1'b0, 8'd3},  // R3 taken
        '{6'd4,  6'h00, 16'd25,   26'd0,    1'b0, 32'h0,        32'h00000074, 1'b0, 8'd3},  // R3 not taken
        '{6'd5,  6'h00, 16'd3,    26'd0,    1'b0, 32'h0,        32'h00000084, 1'b0, 8'd4},  // R4 taken
        '{6'd5,  6'h00, 16'd3,    26'd0,    1'b1, 32'h0,        32'h00000088, 1'b0, 8'd4},  // R4 not taken
        '{6'd5,  6'h00, 16'hFFFE, 26'd0,    1'b0, 32'h0,        32'h00000084, 1'b0, 8'd5},  // R5 backward
        '{6'd2,  6'h00, 16'h0000, 26'd2500, 1'b0, 32'h0,        32'h00002710, 1'b0, 8'd6},  // R6 jump
        '{6'd3,  6'h00, 16'h0000, 26'h40,   1'b0, 32'h0,        32'h00000100, 1'b1, 8'd7},  // R7 call
        '{6'd0,  6'd8,  16'h0000, 26'd0,    1'b0, 32'h00002714, 32'h00002714, 1'b0, 8'd8},  // R8 return
        '{6'd0,  6'd8,  16'h0000, 26'd0,    1'b0, 32'h0FFFFFFC, 32'h0FFFFFFC, 1'b0, 8'd8},  // R8 indirect
        '{6'd2,  6'h00, 16'h0000, 26'd5,    1'b0, 32'h0,        32'h10000014, 1'b0, 8'd10}, // R10 region
        '{6'd4,  6'h00, 16'h8000, 26'd0,    1'b1, 32'h0,        32'h0FFE0018, 1'b0, 8'd5},  // R5 far back
        '{6'd3,  6'h00, 16'h0000, 26'd0,    1'b0, 32'h0,        32'h00000000, 1'b1, 8'd7}   // R7 call to 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [15:0] br_disp = '0;
    logic [25:0] jmp_field = '0;
    logic        eq_flag = 1'b0;
    logic [31:0] jr_value = '0;
    logic [31:0] pc;
    logic [31:0] link_value;
    logic        link_we;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_cur;

    always #2 clk = ~clk;

    pc_sequencer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .funct      (funct),
        .br_disp    (br_disp),
        .jmp_field  (jmp_field),
        .eq_flag    (eq_flag),
        .jr_value   (jr_value),
        .pc         (pc),
        .link_value (link_value),
        .link_we    (link_we)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        opcode    = v.op;
        funct     = v.fn;
        br_disp   = v.disp;
        jmp_field = v.fld;
        eq_flag   = v.eq;
        jr_value  = v.jrv;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        #1;
        check32("R1 reset pc", pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_cur = 32'h0;

        // Vector walk: link outputs before the edge (R9, R7), then the PC after it.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #1;
            check32("R9 link_value", link_value, exp_cur + 32'd4);
            check32((VEC[i].req == 8'd7) ? "R7 link_we" : "R9 link_we",
                    {31'b0, link_we}, {31'b0, VEC[i].exp_we});
            @(posedge clk);
            #1;
            check32($sformatf("R%0d next pc (row %0d)", VEC[i].req, i), pc, VEC[i].exp_pc);
            exp_cur = VEC[i].exp_pc;
            @(negedge clk);
        end

        // R1: reset wins over a jump presented in the same cycle.
        drive('{6'd2, 6'd0, 16'd0, 26'd77, 1'b0, 32'd0, 32'd0, 1'b0, 8'd1});
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check32("R1 reset over jump", pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: the indirect jump keeps link_we low.
        drive('{6'd0, 6'd8, 16'd0, 26'd0, 1'b0, 32'h00ABCDE0, 32'd0, 1'b0, 8'd8});
        #1;
        check32("R8 link_we low", {31'b0, link_we}, 32'h0);
        @(posedge clk);
        #1;
        check32("R8 pc", pc, 32'h00ABCDE0);
        @(negedge clk);
        // R2: opcode 0 with a non-jump function code steps.
        drive('{6'd0, 6'd9, 16'd0, 26'd0, 1'b0, 32'hFFFF0000, 32'd0, 1'b0, 8'd2});
        @(posedge clk);
        #1;
        check32("R2 funct 9 steps", pc, 32'h00ABCDE4);
        @(negedge clk);
        // R1: mid-run reset.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check32("R1 mid-run reset", pc, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule